// File: doc/BRIEF.md
# Masked Edge-Latched Interrupt Controller

This block gathers level-type interrupt status lines from several event sources. It folds them into a fixed-width status word and gates each bit with a per-bit enable held in a mask register. Each rising edge of a gated bit is recorded in a sticky pending register. While any pending bit is set, an active-low request line is driven low toward the host. The request is meant to drive an open-drain pad, so the block only ever signals it low.

Most status bits come straight from one source each. The last bit is shared: it is high whenever any source in a small group is high. The host reaches the block through a small synchronous register port. Through it the host can read the live folded status, write and read the mask, and read the pending register. Reading the pending register also clears it, in the same transaction. The status lines may drop by themselves once their source has been serviced, and a drop never removes a pending bit.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After synchronous reset the mask is zero, the pending register is zero, `irq_n` is 1 and every register read returns 0.
- R2: A write with address 1 loads the mask from `reg_wdata[14:0]`. Reading address 1 returns the mask with bit 15 as 0. Writes to addresses 0, 2 and 3 leave the mask unchanged.
- R3: Reading address 2 returns the live folded status, whatever the mask holds. Bits 0..13 equal `src_lvl[13:0]`, bit 14 is the OR of `src_lvl[17:14]`, and bit 15 is 0.
- R4: A 0-to-1 change of (folded status AND mask) between consecutive clock edges sets the matching pending bit at that edge. A level that stays high does not set the bit again after it has been cleared.
- R5: A status bit whose mask bit is 0 never sets its pending bit and never pulls `irq_n` low.
- R6: `irq_n` is 0 exactly while at least one pending bit is set.
- R7: A read at address 0 returns the pending register, with bit 15 as 0, one cycle after the strobe. The same strobe clears the register.
- R8: A rising edge in the same cycle as a clearing read leaves that bit set after the read.
- R9: Setting a mask bit while its status is already high counts as a rising edge and sets the pending bit one edge after the mask update.
- R10: A falling status or mask bit does not clear a pending bit.
- R11: A read at address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_lvl | input | 18 | Raw level status: 14 direct sources, then 4 grouped sources |
| reg_addr | input | 2 | Register address: 0 pending, 1 mask, 2 live status, 3 reserved |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rd | input | 1 | Read strobe; a read at address 0 clears the pending register |
| reg_rdata | output | 16 | Read data, registered, valid the cycle after the strobe |
| irq_n | output | 1 | Active-low interrupt request, for an open-drain pad |

## Verification
The bench uses the default parameters: 14 direct sources and a group of 4 folded into bit 14. That gives only 18 raw lines and 15 mask bits, so every raw line and every mask bit can be swept one-hot. Expected values come from a folding function written in the bench. At this size every grouped source can be shown to reach bit 14. The bench also times exact cases: an edge that lands on the clearing read, and a mask that is enabled while its source is already high.

// File: rtl/irqc_pkg.sv
// Package irqc_pkg
// Shared register address codes for the interrupt controller.
// Assumes a 2-bit register address.
package irqc_pkg;
    typedef enum logic [1:0] {
        ADDR_PEND = 2'd0,
        ADDR_MASK = 2'd1,
        ADDR_LIVE = 2'd2,
        ADDR_RSVD = 2'd3
    } irqc_addr_e;
endpackage

// File: rtl/irqc_fold.sv
// Module irqc_fold
// Folds the raw source lines into the interrupt status word.
// Each direct source drives its own bit. The grouped sources are ORed into the top bit.
// Purely combinational. Assumes N_GROUP >= 0.
module irqc_fold #(
    parameter int N_DIRECT = 14,
    parameter int N_GROUP  = 4,
    localparam int N_RAW   = N_DIRECT + N_GROUP,
    localparam int N_IRQ   = N_DIRECT + 1
) (
    input  logic [N_RAW-1:0] raw,
    output logic [N_IRQ-1:0] folded
);
    // route each direct source to its own status bit
    for (genvar g = 0; g < N_DIRECT; g++) begin : g_direct
        assign folded[g] = raw[g];
    end

    // combine the shared group into the top status bit
    if (N_GROUP > 0) begin : g_group
        assign folded[N_DIRECT] = |raw[N_RAW-1:N_DIRECT];
    end else begin : g_nogroup
        assign folded[N_DIRECT] = 1'b0;
    end
endmodule

// File: rtl/irqc_edge_latch.sv
// Module irqc_edge_latch
// Gates the live status with the mask and finds rising edges against last cycle's gated value.
// Records those edges in a sticky pending register.
// A clear pulse empties the register, but an edge arriving in the same cycle survives it.
// Assumes clr is a single-cycle pulse from the register port.
module irqc_edge_latch #(
    parameter int N_IRQ = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] live,
    input  logic [N_IRQ-1:0] mask,
    input  logic             clr,
    output logic [N_IRQ-1:0] pend
);
    logic [N_IRQ-1:0] gated;
    logic [N_IRQ-1:0] gated_q;
    logic [N_IRQ-1:0] edges;

    // apply the enables and detect 0-to-1 transitions
    always_comb begin
        gated = live & mask;
        edges = gated & ~gated_q;
    end

    // remember the gated status for next cycle's comparison
    always_ff @(posedge clk) begin
        if (!rst_n) gated_q <= '0;
        else        gated_q <= gated;
    end

    // sticky pending bits: cleared by read, new edges always win
    always_ff @(posedge clk) begin
        if (!rst_n)   pend <= '0;
        else if (clr) pend <= edges;
        else          pend <= pend | edges;
    end

    // R4
    rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|edges) |=> ((pend & $past(edges)) == $past(edges)));
    // R7
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && edges == '0) |=> (pend == '0));
    // R10
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((pend & $past(pend)) == $past(pend)));
    // R5
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & ~$past(pend) & ~$past(mask)) == '0));
endmodule

// File: rtl/irqc_regport.sv
// Module irqc_regport
// Host register port. Holds the mask and drives the registered read data.
// Issues the clear pulse for a read of the pending register.
// Assumes DATA_W > N_IRQ. Unused upper bits read as zero.
module irqc_regport
    import irqc_pkg::*;
#(
    parameter int N_IRQ  = 15,
    parameter int DATA_W = 16,
    localparam int PAD_W = DATA_W - N_IRQ
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [N_IRQ-1:0]  live,
    input  logic [N_IRQ-1:0]  pend,
    output logic [N_IRQ-1:0]  mask,
    output logic              clr,
    output logic [DATA_W-1:0] rd_data
);
    irqc_addr_e       sel;
    logic [N_IRQ-1:0] rd_mux;
    logic             unused_wr_hi;

    assign sel          = irqc_addr_e'(addr);
    assign unused_wr_hi = ^wr_data[DATA_W-1:N_IRQ];

    // a read of the pending register requests its clear
    assign clr = rd_en && (sel == ADDR_PEND);

    // mask register, written only at its own address
    always_ff @(posedge clk) begin
        if (!rst_n)                           mask <= '0;
        else if (wr_en && sel == ADDR_MASK)   mask <= wr_data[N_IRQ-1:0];
    end

    // pick the register the host addressed
    always_comb begin
        case (sel)
            ADDR_PEND: rd_mux = pend;
            ADDR_MASK: rd_mux = mask;
            ADDR_LIVE: rd_mux = live;
            default:   rd_mux = '0;
        endcase
    end

    // capture read data on the strobe, zero-extended
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= {{PAD_W{1'b0}}, rd_mux};
    end

    // R2
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd1) |=> (mask == $past(wr_data[N_IRQ-1:0])));
    // R11
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd3) |=> (rd_data == '0));
endmodule

// File: rtl/edge_irq_ctrl.sv
// Module edge_irq_ctrl (top)
// Masked, edge-latched interrupt controller with a clear-on-read pending register.
// irq_n is low while any pending bit is set. It is meant for an open-drain pad.
// Assumes synchronous, glitch-free source levels in the clk domain.
module edge_irq_ctrl #(
    parameter int N_DIRECT = 14,
    parameter int N_GROUP  = 4,
    parameter int DATA_W   = 16,
    localparam int N_RAW   = N_DIRECT + N_GROUP,
    localparam int N_IRQ   = N_DIRECT + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_RAW-1:0]  src_lvl,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_n
);
    logic [N_IRQ-1:0] live;
    logic [N_IRQ-1:0] mask;
    logic [N_IRQ-1:0] pend;
    logic             clr;

    irqc_fold #(.N_DIRECT(N_DIRECT), .N_GROUP(N_GROUP)) u_fold (
        .raw(src_lvl), .folded(live)
    );

    irqc_edge_latch #(.N_IRQ(N_IRQ)) u_latch (
        .clk(clk), .rst_n(rst_n), .live(live), .mask(mask), .clr(clr), .pend(pend)
    );

    irqc_regport #(.N_IRQ(N_IRQ), .DATA_W(DATA_W)) u_port (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr_en(reg_wr), .wr_data(reg_wdata),
        .rd_en(reg_rd), .live(live), .pend(pend), .mask(mask), .clr(clr), .rd_data(reg_rdata)
    );

    // request pulled low while anything is pending
    assign irq_n = ~|pend;

    // R6
    req_follows_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd0 && $past(live & mask) == (live & mask)) |=> irq_n);
endmodule

// File: tb/sim_edge_irq_ctrl.sv
`timescale 1ns/1ps
module sim_edge_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [17:0] src_lvl;
    logic [1:0]  reg_addr;
    logic        reg_wr;
    logic [15:0] reg_wdata;
    logic        reg_rd;
    logic [15:0] reg_rdata;
    logic        irq_n;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    edge_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    function automatic logic [15:0] fold(input logic [17:0] r);
        return {1'b0, |r[17:14], r[13:0]};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1;
        @(posedge clk); #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic set_src(input logic [17:0] v);
        @(negedge clk); src_lvl = v;
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        rst_n = 1'b0; src_lvl = '0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0; reg_rd = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        check("R1 irq_n", {15'd0, irq_n}, 16'd1);
        for (int a = 0; a < 3; a++) begin
            rd(2'(a), d); check("R1 read", d, 16'h0000);
        end

        // R2 mask one-hot sweep, bit 15 ignored
        for (int i = 0; i < 15; i++) begin
            wr(2'd1, 16'h8000 | (16'd1 << i));
            rd(2'd1, d); check("R2 mask readback", d, 16'd1 << i);
        end
        wr(2'd1, 16'h1234);
        wr(2'd0, 16'h7FFF); wr(2'd2, 16'h7FFF); wr(2'd3, 16'h7FFF);
        rd(2'd1, d); check("R2 other addr ignored", d, 16'h1234);

        // R3 and R5: live status sweep with mask zero
        wr(2'd1, 16'h0000);
        for (int i = 0; i < 18; i++) begin
            set_src(18'd1 << i);
            rd(2'd2, d); check("R3 live fold", d, fold(18'd1 << i));
            check("R5 irq_n masked", {15'd0, irq_n}, 16'd1);
        end
        set_src('0);
        rd(2'd0, d); check("R5 nothing pending", d, 16'h0000);

        // R4 R6 R7 with all enabled, every raw line
        wr(2'd1, 16'h7FFF);
        for (int i = 0; i < 18; i++) begin
            set_src('0);
            rd(2'd0, d);
            set_src(18'd1 << i);
            @(negedge clk);
            check("R6 irq_n low", {15'd0, irq_n}, 16'd0);
            rd(2'd0, d); check("R4 R7 pending read", d, fold(18'd1 << i));
            check("R6 irq_n released", {15'd0, irq_n}, 16'd1);
            rd(2'd0, d); check("R4 held level no re-set", d, 16'h0000);
        end

        // R10 falling status keeps pending
        set_src('0); rd(2'd0, d);
        set_src(18'd1 << 7);
        set_src('0);
        wr(2'd1, 16'h0000);
        rd(2'd0, d); check("R10 sticky after fall", d, 16'h0080);
        wr(2'd1, 16'h7FFF);

        // R8 edge coincident with clearing read
        set_src('0); rd(2'd0, d);
        @(negedge clk); src_lvl = 18'd1 << 3; reg_addr = 2'd0; reg_rd = 1'b1;
        @(posedge clk); #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
        check("R8 read saw old value", d, 16'h0000);
        check("R8 irq_n still low", {15'd0, irq_n}, 16'd0);
        rd(2'd0, d); check("R8 bit kept", d, 16'h0008);

        // R9 enabling mask over a high status
        wr(2'd1, 16'h0000);
        set_src(18'd1 << 5);
        @(negedge clk);
        rd(2'd0, d); check("R9 nothing before enable", d, 16'h0000);
        wr(2'd1, 16'h0020);
        @(negedge clk);
        rd(2'd0, d); check("R9 enable counts as edge", d, 16'h0020);

        // R5 partial mask with every source rising together
        set_src('0);
        wr(2'd1, 16'h00FF);
        rd(2'd0, d);
        set_src('1);
        @(negedge clk);
        rd(2'd0, d); check("R5 partial mask", d, 16'h00FF);

        // R11 reserved address
        rd(2'd3, d); check("R11 reserved zero", d, 16'h0000);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule